// File: doc/BRIEF.md
# Memory Read Request Splitter

This block turns one large read job from a DMA engine into a series of memory read requests. A job is a dword-aligned start address and a byte length. The block cuts the job into consecutive requests. Each request is no larger than the maximum read request size currently programmed, and none crosses a 4 KB address boundary. Each request carries a header tag from a small pool. The pool limits how many reads are outstanding at once. A tag goes back into the pool only when the completion logic reports, on the tag-return input, that all data for that tag has arrived.

Jobs enter on a valid/ready handshake. `job_ready` is high only while the block is idle, so one job is handled at a time. Requests leave on a valid/ready channel. Once `req_valid` is high, the address, length and tag are held unchanged until `req_ready` accepts them, and `req_valid` is never withdrawn. Back-pressure on the request channel only delays issue. The configuration word and the tag-return input are plain pins. When the last request has been issued and every tag is home again, `job_done` pulses for one cycle.

Top module: `rd_splitter`

## Requirements
- R1: The maximum request size is taken from bits 14:12 of `cfg_devctl`. Code 000 gives 128 bytes, 001 gives 256, 010 gives 512, 011 gives 1024, 100 gives 2048 and 101 gives 4096. No other bit of the word has any effect.
- R2: Codes 110 and 111 are treated as 128 bytes.
- R3: Requests cover the job in order with no gaps. Each request starts where the previous one ended, and its length in bytes is the smallest of three values: the bytes remaining, the maximum size, and the bytes up to the next 4 KB boundary. `req_dw` gives that length in 4-byte dwords.
- R4: No request crosses a 4 KB address boundary, and no request has zero length.
- R5: The size code is sampled when the job is accepted. A change to `cfg_devctl` during the job does not change the job's request sizes.
- R6: Every request carries a tag that is not outstanding. The tag issued is the lowest-numbered free one. So with four tags, when tag 0 has been returned after four requests, the fifth request reuses tag 0.
- R7: While all tags are outstanding, `req_valid` stays low.
- R8: A tag becomes free only when `tag_ret_valid` is high with that tag on `tag_ret_id`. Returning one tag frees that tag and no other.
- R9: While `req_valid` is high and `req_ready` is low, `req_valid` stays high and `req_addr`, `req_dw` and `req_tag` do not change.
- R10: `job_done` is a one-cycle pulse. It is raised once after the last request of a job has been accepted and every tag has been returned. A job of length zero issues no request and still raises `job_done`.
- R11: After reset, `job_ready` is high and `req_valid` and `job_done` are low. `job_ready` is high only while the block is idle, and `req_valid` is never high while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_devctl | input | 16 | Device control word; bits 14:12 hold the size code |
| job_valid | input | 1 | Job offered |
| job_ready | output | 1 | Block idle and able to take a job |
| job_addr | input | ADDR_W | Job start address, dword aligned |
| job_len | input | LEN_W | Job length in bytes, multiple of 4 |
| req_valid | output | 1 | Read request offered |
| req_ready | input | 1 | Read request taken |
| req_addr | output | ADDR_W | Request start address |
| req_dw | output | 11 | Request length in dwords |
| req_tag | output | TAG_W | Request tag |
| tag_ret_valid | input | 1 | A tag's completion data has all arrived |
| tag_ret_id | input | TAG_W | Tag being returned |
| job_done | output | 1 | One-cycle pulse at the end of a job |

## Verification
The bench goes after several corner cases. The first is a job that starts just below a 4 KB boundary. A splitter that ignored the boundary would issue one request straddling it, and one that shortened only by size would misplace every later address. The bench also covers the reserved size codes, a size change in the middle of a job, and a zero-length job. A wrong design would issue 4 KB requests for the reserved codes, switch sizes partway through the job, or never raise done on the zero-length job. With tag returns withheld, the bench checks that exactly four requests go out and that returns issued out of order are reused lowest-first. A design that recycled tags early, or that raised done early, would show a fifth request or a premature pulse. Holding `req_ready` low checks that a stalled request stays put and is not replaced.

// File: rtl/rsplit_pkg.sv
package rsplit_pkg;
  // size code position inside the device control word
  localparam int SZ_FIELD_LSB = 12;
  // address boundary that a request may not cross (log2 bytes)
  localparam int BOUND_LG = 12;
  localparam int SZ_W = BOUND_LG + 1;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2
  } split_state_t;

  function automatic logic [SZ_W-1:0] size_from_code(input logic [2:0] code);
    logic [SZ_W-1:0] base;
    base = SZ_W'(128);
    if (code <= 3'd5) return base << code;
    return base;
  endfunction
endpackage

// File: rtl/rsplit_tag_pool.sv
module rsplit_tag_pool #(
  parameter int TAG_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc,
  input  logic             ret_valid,
  input  logic [TAG_W-1:0] ret_id,
  output logic             any_free,
  output logic             all_free,
  output logic [TAG_W-1:0] free_id
);
  localparam int NUM_TAGS = 1 << TAG_W;

  logic [NUM_TAGS-1:0] busy_q;
  logic [NUM_TAGS-1:0] take_mask;
  logic [NUM_TAGS-1:0] give_mask;

  // lowest-numbered free tag wins
  always_comb begin
    free_id = '0;
    for (int i = NUM_TAGS - 1; i >= 0; i--) begin
      if (!busy_q[i]) free_id = TAG_W'(i);
    end
  end

  assign any_free  = ~&busy_q;
  assign all_free  = ~|busy_q;
  assign take_mask = alloc ? (NUM_TAGS'(1) << free_id) : '0;
  assign give_mask = ret_valid ? (NUM_TAGS'(1) << ret_id) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) busy_q <= '0;
    else        busy_q <= (busy_q | take_mask) & ~give_mask;
  end
endmodule

// File: rtl/rsplit_chunk.sv
module rsplit_chunk
  import rsplit_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 24
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [LEN_W-1:0]  remain,
  input  logic [SZ_W-1:0]   max_bytes,
  output logic [SZ_W-1:0]   chunk
);
  localparam logic [SZ_W-1:0] BOUND = SZ_W'(1) << BOUND_LG;

  logic [SZ_W-1:0] to_bound;
  logic [SZ_W-1:0] size_cap;

  assign to_bound = BOUND - {1'b0, addr[BOUND_LG-1:0]};
  assign size_cap = (to_bound < max_bytes) ? to_bound : max_bytes;

  always_comb begin
    if (remain < LEN_W'(size_cap)) chunk = SZ_W'(remain);
    else                           chunk = size_cap;
  end
endmodule

// File: rtl/rd_splitter.sv
module rd_splitter
  import rsplit_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 24,
  parameter int TAG_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       cfg_devctl,
  input  logic              job_valid,
  output logic              job_ready,
  input  logic [ADDR_W-1:0] job_addr,
  input  logic [LEN_W-1:0]  job_len,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  output logic [SZ_W-3:0]   req_dw,
  output logic [TAG_W-1:0]  req_tag,
  input  logic              tag_ret_valid,
  input  logic [TAG_W-1:0]  tag_ret_id,
  output logic              job_done
);
  localparam int DW_W = SZ_W - 2;

  split_state_t      state_q;
  logic [ADDR_W-1:0] cur_addr_q;
  logic [LEN_W-1:0]  remain_q;
  logic [SZ_W-1:0]   max_q;
  logic              out_v_q;
  logic [ADDR_W-1:0] out_addr_q;
  logic [DW_W-1:0]   out_dw_q;
  logic [TAG_W-1:0]  out_tag_q;
  logic              done_q;

  logic [SZ_W-1:0]   chunk_b;
  logic              any_free;
  logic              all_free;
  logic [TAG_W-1:0]  free_id;
  logic              accept;
  logic              load;

  rsplit_chunk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_chunk (
    .addr      (cur_addr_q),
    .remain    (remain_q),
    .max_bytes (max_q),
    .chunk     (chunk_b)
  );

  rsplit_tag_pool #(.TAG_W(TAG_W)) u_tags (
    .clk       (clk),
    .rst_n     (rst_n),
    .alloc     (load),
    .ret_valid (tag_ret_valid),
    .ret_id    (tag_ret_id),
    .any_free  (any_free),
    .all_free  (all_free),
    .free_id   (free_id)
  );

  assign job_ready = (state_q == ST_IDLE);
  assign accept    = job_valid && job_ready;
  // a new request enters the output register when a tag is free and the slot is open
  assign load      = (state_q == ST_RUN) && any_free && (!out_v_q || req_ready);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      cur_addr_q <= '0;
      remain_q   <= '0;
      max_q      <= SZ_W'(128);
      done_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            cur_addr_q <= job_addr;
            remain_q   <= job_len;
            max_q      <= size_from_code(cfg_devctl[SZ_FIELD_LSB +: 3]);
            state_q    <= (job_len == '0) ? ST_DRAIN : ST_RUN;
          end
        end
        ST_RUN: begin
          if (load) begin
            cur_addr_q <= cur_addr_q + ADDR_W'(chunk_b);
            remain_q   <= remain_q - LEN_W'(chunk_b);
            if (remain_q == LEN_W'(chunk_b)) state_q <= ST_DRAIN;
          end
        end
        ST_DRAIN: begin
          if (!out_v_q && all_free) begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_v_q    <= 1'b0;
      out_addr_q <= '0;
      out_dw_q   <= '0;
      out_tag_q  <= '0;
    end else if (load) begin
      out_v_q    <= 1'b1;
      out_addr_q <= cur_addr_q;
      out_dw_q   <= chunk_b[SZ_W-1:2];
      out_tag_q  <= free_id;
    end else if (req_ready) begin
      out_v_q    <= 1'b0;
    end
  end

  assign req_valid = out_v_q;
  assign req_addr  = out_addr_q;
  assign req_dw    = out_dw_q;
  assign req_tag   = out_tag_q;
  assign job_done  = done_q;
endmodule

// File: rtl/rsplit_chk.sv
module rsplit_chk #(
  parameter int ADDR_W = 32,
  parameter int TAG_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              job_ready,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic [10:0]       req_dw,
  input logic [TAG_W-1:0]  req_tag,
  input logic              tag_ret_valid,
  input logic [TAG_W-1:0]  tag_ret_id,
  input logic              job_done
);
  localparam int NT = 1 << TAG_W;

  logic [NT-1:0] held_q;
  logic [13:0]   end_off;

  always_ff @(posedge clk) begin
    if (!rst_n) held_q <= '0;
    else held_q <= (held_q | ((req_valid && req_ready) ? (NT'(1) << req_tag) : '0))
                   & ~(tag_ret_valid ? (NT'(1) << tag_ret_id) : '0);
  end

  assign end_off = {2'b00, req_addr[11:0]} + {1'b0, req_dw, 2'b00};

  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_dw) && $stable(req_tag)));

  assert_no_cross_R4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_dw != 11'd0 && end_off <= 14'd4096));

  assert_tag_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |-> !held_q[req_tag]);

  assert_done_clean_R10: assert property (@(posedge clk) disable iff (!rst_n)
    job_done |-> (held_q == '0 && !req_valid));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    job_done |=> !job_done);

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    job_ready |-> !req_valid);
endmodule

bind rd_splitter rsplit_chk #(.ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_rsplit_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .job_ready     (job_ready),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .req_addr      (req_addr),
  .req_dw        (req_dw),
  .req_tag       (req_tag),
  .tag_ret_valid (tag_ret_valid),
  .tag_ret_id    (tag_ret_id),
  .job_done      (job_done)
);

// File: tb/test_rd_splitter.sv
module test_rd_splitter;
  localparam int CLK_P = 10;

  typedef struct packed {
    logic [31:0] a;
    logic [23:0] l;
    logic [2:0]  c;
  } vec_t;

  // start address, byte length, size code
  localparam vec_t VECS [7] = '{
    '{32'h0000_1000, 24'd512,  3'd0},
    '{32'h0000_0F80, 24'd1024, 3'd2},
    '{32'h0000_2000, 24'd8192, 3'd5},
    '{32'h0000_3FFC, 24'd8,    3'd1},
    '{32'h0000_0100, 24'd768,  3'd6},
    '{32'h0000_0500, 24'd0,    3'd3},
    '{32'h0002_0000, 24'd6144, 3'd4}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cfg_devctl = 16'h0;
  logic        job_valid = 1'b0;
  logic        job_ready;
  logic [31:0] job_addr = '0;
  logic [23:0] job_len = '0;
  logic        req_valid;
  logic        req_ready = 1'b1;
  logic [31:0] req_addr;
  logic [10:0] req_dw;
  logic [1:0]  req_tag;
  logic        tag_ret_valid = 1'b0;
  logic [1:0]  tag_ret_id = '0;
  logic        job_done;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  logic [31:0] rec_a [64];
  logic [10:0] rec_d [64];
  logic [1:0]  rec_t [64];
  int rec_n = 0;
  int done_cnt = 0;
  int bad_tag = 0;
  logic [3:0] bt_out = '0;

  logic [31:0] exp_a [64];
  logic [10:0] exp_d [64];
  int exp_n = 0;

  logic auto_en = 1'b1;
  logic man_req = 1'b0;
  logic [1:0] man_tag = '0;

  rd_splitter i_rd_splitter (
    .clk(clk), .rst_n(rst_n), .cfg_devctl(cfg_devctl),
    .job_valid(job_valid), .job_ready(job_ready), .job_addr(job_addr), .job_len(job_len),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_dw(req_dw),
    .req_tag(req_tag), .tag_ret_valid(tag_ret_valid), .tag_ret_id(tag_ret_id),
    .job_done(job_done)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // monitor: samples just before each rising edge
  always begin
    @(negedge clk);
    #(CLK_P/2 - 1);
    cyc++;
    if (req_valid && req_ready) begin
      if (bt_out[req_tag]) bad_tag++;
      bt_out[req_tag] = 1'b1;
      if (rec_n < 64) begin
        rec_a[rec_n] = req_addr;
        rec_d[rec_n] = req_dw;
        rec_t[rec_n] = req_tag;
      end
      rec_n++;
    end
    if (job_done) done_cnt++;
    if (cyc > 150000) begin
      fails++;
      checks++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected below 150000", cyc);
      finish_run();
    end
  end

  // completion side: returns tags
  always @(negedge clk) begin
    if (man_req) begin
      tag_ret_valid = 1'b1;
      tag_ret_id = man_tag;
      bt_out[man_tag] = 1'b0;
      man_req = 1'b0;
    end else if (auto_en && bt_out != 4'b0) begin
      logic [1:0] t;
      t = 2'd0;
      for (int i = 3; i >= 0; i--) if (bt_out[i]) t = 2'(i);
      tag_ret_valid = 1'b1;
      tag_ret_id = t;
      bt_out[t] = 1'b0;
    end else begin
      tag_ret_valid = 1'b0;
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] cfg_word(input logic [2:0] code);
    return (16'hA05F & ~16'h7000) | (16'(code) << 12);
  endfunction

  task automatic model(input logic [31:0] a, input logic [23:0] l, input logic [2:0] c);
    longint mx, ad, rm, tb, ch;
    mx = (c <= 3'd5) ? (128 << c) : 128;
    ad = a;
    rm = l;
    exp_n = 0;
    while (rm > 0) begin
      tb = 4096 - (ad % 4096);
      ch = rm;
      if (mx < ch) ch = mx;
      if (tb < ch) ch = tb;
      exp_a[exp_n] = 32'(ad);
      exp_d[exp_n] = 11'(ch / 4);
      exp_n++;
      ad += ch;
      rm -= ch;
    end
  endtask

  task automatic clear_rec();
    rec_n = 0;
    done_cnt = 0;
    bad_tag = 0;
  endtask

  task automatic apply_job(input logic [31:0] a, input logic [23:0] l, input logic [2:0] c,
                           input bit change_cfg);
    @(negedge clk);
    cfg_devctl = cfg_word(c);
    job_addr = a;
    job_len = l;
    job_valid = 1'b1;
    @(negedge clk);
    job_valid = 1'b0;
    if (change_cfg) cfg_devctl = cfg_word(3'd5);
  endtask

  task automatic wait_done();
    int n;
    n = 0;
    while (done_cnt == 0 && n < 5000) begin
      @(negedge clk);
      n++;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic compare_all(input string req);
    check(rec_n == exp_n, {req, " request count"}, rec_n, exp_n);
    for (int i = 0; i < exp_n && i < rec_n; i++) begin
      check(rec_a[i] == exp_a[i] && rec_d[i] == exp_d[i], {req, " request addr/len"},
            {rec_a[i], 5'b0, rec_d[i]}, {exp_a[i], 5'b0, exp_d[i]});
    end
    check(bad_tag == 0, "R6 tag reused while outstanding", bad_tag, 0);
    check(done_cnt == 1, "R10 done pulse count", done_cnt, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check(job_ready == 1'b1, "R11 job_ready after reset", job_ready, 1);
    check(req_valid == 1'b0, "R11 req_valid after reset", req_valid, 0);
    check(job_done == 1'b0, "R11 job_done after reset", job_done, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(job_ready == 1'b1 && req_valid == 1'b0, "R11 idle after reset release",
          {job_ready, req_valid}, 2'b10);

    // table walk: R1 R2 R3 R4 R10
    for (int v = 0; v < 7; v++) begin
      clear_rec();
      model(VECS[v].a, VECS[v].l, VECS[v].c);
      apply_job(VECS[v].a, VECS[v].l, VECS[v].c, 1'b0);
      wait_done();
      compare_all("R1/R2/R3 table");
    end

    // R5: size change after acceptance has no effect on the running job
    clear_rec();
    model(32'h0004_0000, 24'd1024, 3'd0);
    apply_job(32'h0004_0000, 24'd1024, 3'd0, 1'b1);
    wait_done();
    compare_all("R5 size held for job");

    // R6 R7 R8: tag exhaustion and lowest-free reuse
    clear_rec();
    auto_en = 1'b0;
    model(32'h0000_8000, 24'd1024, 3'd0);
    apply_job(32'h0000_8000, 24'd1024, 3'd0, 1'b0);
    repeat (20) @(negedge clk);
    check(rec_n == 4, "R7 issue stops with pool empty", rec_n, 4);
    check(req_valid == 1'b0, "R7 req_valid low while pool empty", req_valid, 0);
    check(rec_t[0] == 2'd0 && rec_t[1] == 2'd1 && rec_t[2] == 2'd2 && rec_t[3] == 2'd3,
          "R6 first four tags in order", {rec_t[0], rec_t[1], rec_t[2], rec_t[3]}, 8'h1B);
    check(done_cnt == 0, "R10 no done while tags out", done_cnt, 0);
    man_tag = 2'd0;
    man_req = 1'b1;
    repeat (5) @(negedge clk);
    check(rec_n == 5 && rec_t[4] == 2'd0, "R6 fifth request reuses tag 0",
          {rec_n[7:0], 6'b0, rec_t[4]}, {8'd5, 8'd0});
    man_tag = 2'd2;
    man_req = 1'b1;
    repeat (5) @(negedge clk);
    check(rec_n == 6 && rec_t[5] == 2'd2, "R8 only returned tag 2 freed",
          {rec_n[7:0], 6'b0, rec_t[5]}, {8'd6, 8'd2});
    check(done_cnt == 0, "R10 no done before all returned", done_cnt, 0);
    auto_en = 1'b1;
    wait_done();
    compare_all("R8 drain after manual returns");

    // R9: back-pressure holds the request steady
    clear_rec();
    req_ready = 1'b0;
    model(32'h0000_9000, 24'd512, 3'd0);
    apply_job(32'h0000_9000, 24'd512, 3'd0, 1'b0);
    repeat (2) @(negedge clk);
    check(req_valid == 1'b1 && req_addr == 32'h9000 && req_dw == 11'd32,
          "R9 request offered under back-pressure", {req_valid, req_addr}, {1'b1, 32'h9000});
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(req_valid == 1'b1 && req_addr == 32'h9000 && req_dw == 11'd32 && req_tag == 2'd0,
            "R9 request held stable", {req_valid, req_addr, req_tag}, {1'b1, 32'h9000, 2'd0});
    end
    req_ready = 1'b1;
    wait_done();
    compare_all("R9 after release");

    finish_run();
  end
endmodule